// File: doc/BRIEF.md
# Power-Sourcing Port Detect, Classify and Power-On Sequencer

This block steps each of a parameterised number of power-sourcing ports (four by default) through the start-up of a powered device. For each port it runs a two-phase signature detection, an optional classification and then turns on the port's gate drive. The ports run independently of each other. Voltage forcing and conversion are outside the block. For each port it raises a measurement request that names the kind of measurement wanted. It then takes back a code with a one-cycle valid strobe.

Detection takes two voltage codes, one for each forced test current. It uses their difference as the resistive slope, so that a fixed diode drop or leakage offset cancels. The slope is compared against a programmable window. A port in automatic mode chains detection, classification and power-on with no host action. A port in semi-automatic mode stops after classification until the host pulses power-on. In manual mode the host alone decides. A per-port settle count holds off each measurement request.

Top module: `poeSequencer`

## Requirements
- R1: After reset every gateOn, measReq, detectEvt and classEvt is 0, and every detResult and classVal is 0.
- R2: A port in automatic (portMode 3) or semi-automatic (portMode 2) mode starts detection only while enableReg bit p is 1. Its classification step runs only while enableReg bit NUM_PORTS+p is 1 at the end of detection. With both bits 0 the port stays idle and never requests.
- R3: Each measurement phase first spends settleCycles+1 cycles settling, then raises measReq. The phases come in the order detect phase 1 (measKind 0), detect phase 2 (measKind 1), class (measKind 2). measKind is 0 while no request is raised.
- R4: measReq stays high with a stable measKind until a cycle with measValid high. It falls in the following cycle.
- R5: The slope is the phase-2 code minus the phase-1 code. detResult becomes 1 (valid) when sigMinCode <= slope <= sigMaxCode, 2 (low or short) when the slope is below sigMinCode or negative, and 3 (high or open) when it is above sigMaxCode. The new value appears in the cycle after detectEvt. detResult and classVal are cleared to 0 in the cycle after detection starts.
- R6: detectEvt is a one-cycle pulse in the cycle after the phase-2 measValid. classEvt is a one-cycle pulse in the cycle after the class measValid.
- R7: In automatic mode a valid signature leads to gateOn in the cycle after classEvt, or in the cycle after detectEvt when classification is disabled. An invalid signature returns the port to idle, and it restarts detection.
- R8: In semi-automatic mode, after a valid signature (and after classification, if enabled), the gate stays off until a hostPwrOn pulse. gateOn is 1 from the next cycle.
- R9: classVal is taken from measCode bits [2:0]. Values 0 to 4 are reported unchanged, so the reserved class 4 stays distinct. Values 5 to 7 are reported as 0. classVal is valid from the classEvt cycle.
- R10: portMode 0 (off) or a hostPwrOff pulse sends the port to idle with the gate off from the next cycle. This wins over a measValid in the same cycle, which is then not captured. Manual mode (portMode 1) aborts any sequence in progress, never requests measurements, and turns the gate on in the cycle after a hostPwrOn pulse.
- R11: Each port's outputs depend only on its own mode, enable bits, pulses and measurement handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| portMode | input | NUM_PORTS x 2 | Per-port mode: 0 off, 1 manual, 2 semi-automatic, 3 automatic |
| enableReg | input | 2*NUM_PORTS | Bit p enables detection of port p; bit NUM_PORTS+p enables its classification |
| settleCycles | input | CNT_W | Settle count before each measurement request |
| sigMinCode | input | CODE_W | Lowest slope accepted as a valid signature |
| sigMaxCode | input | CODE_W | Highest slope accepted as a valid signature |
| hostPwrOn | input | NUM_PORTS | Host power-on pulse per port |
| hostPwrOff | input | NUM_PORTS | Host power-off pulse per port |
| measValid | input | NUM_PORTS | Measurement result valid strobe per port |
| measCode | input | NUM_PORTS x CODE_W | Measurement result code per port |
| measReq | output | NUM_PORTS | Measurement request per port |
| measKind | output | NUM_PORTS x 2 | Requested measurement: 0 detect phase 1, 1 detect phase 2, 2 class |
| gateOn | output | NUM_PORTS | Gate enable per port |
| detResult | output | NUM_PORTS x 2 | Latched detection result: 0 none, 1 valid, 2 low, 3 high |
| classVal | output | NUM_PORTS x 3 | Latched class value |
| detectEvt | output | NUM_PORTS | Detection-complete pulse |
| classEvt | output | NUM_PORTS | Classification-complete pulse |

## Verification
Two pairs of events can fall in the same cycle. The first is a port's returning measurement strobe together with an abort of that port: mode forced off, or a host power-off pulse. The bench provokes it by switching a port off in the very cycle its phase-2 result arrives, and it requires no detection event and no change to the latched result afterwards. The second is completion events on different ports in the same cycle, which arise from the overlapping schedules of the four ports. A behavioural per-cycle model judges every output of every port on each clock.

// File: rtl/poeSeqPkg.sv
package poeSeqPkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DSET1,
    ST_DREQ1,
    ST_DSET2,
    ST_DREQ2,
    ST_DEVAL,
    ST_CSET,
    ST_CREQ,
    ST_CEVAL,
    ST_WAITPWR,
    ST_POWER
  } seqState_t;

  typedef enum logic [1:0] {
    MODE_OFF    = 2'd0,
    MODE_MANUAL = 2'd1,
    MODE_SEMI   = 2'd2,
    MODE_AUTO   = 2'd3
  } portMode_t;

  localparam logic [1:0] KIND_DET1  = 2'd0;
  localparam logic [1:0] KIND_DET2  = 2'd1;
  localparam logic [1:0] KIND_CLASS = 2'd2;

  localparam logic [1:0] SIG_NONE = 2'd0;
  localparam logic [1:0] SIG_GOOD = 2'd1;
  localparam logic [1:0] SIG_LOW  = 2'd2;
  localparam logic [1:0] SIG_HIGH = 2'd3;

  localparam logic [2:0] CLASS_TOP = 3'd4;

  typedef struct packed {
    logic clearRes;
    logic capV1;
    logic capV2;
    logic latchDet;
    logic capClass;
  } seqStrobe_t;

  function automatic logic [2:0] mapClass(input logic [2:0] raw);
    return (raw > CLASS_TOP) ? 3'd0 : raw;
  endfunction

endpackage

// File: rtl/poeSeqCtrl.sv
module poeSeqCtrl
  import poeSeqPkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int CNT_W     = 8
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [NUM_PORTS-1:0][1:0]     portMode,
  input  logic [2*NUM_PORTS-1:0]        enableReg,
  input  logic [CNT_W-1:0]              settleCycles,
  input  logic [NUM_PORTS-1:0]          hostPwrOn,
  input  logic [NUM_PORTS-1:0]          hostPwrOff,
  input  logic [NUM_PORTS-1:0]          measValid,
  input  logic [NUM_PORTS-1:0]          sigOk,
  output seqStrobe_t [NUM_PORTS-1:0]    strobes,
  output logic [NUM_PORTS-1:0]          measReq,
  output logic [NUM_PORTS-1:0][1:0]     measKind,
  output logic [NUM_PORTS-1:0]          gateOn,
  output logic [NUM_PORTS-1:0]          detectEvt,
  output logic [NUM_PORTS-1:0]          classEvt
);

  for (genvar g = 0; g < NUM_PORTS; g++) begin : gPort
    seqState_t       curSt, nxtSt;
    logic [CNT_W-1:0] cnt, cntNxt;
    seqStrobe_t      stb;
    portMode_t       modeP;
    logic            autoLike;
    logic            detOn, clsOn;
    logic            settled;

    assign modeP    = portMode_t'(portMode[g]);
    assign autoLike = (modeP == MODE_SEMI) || (modeP == MODE_AUTO);
    assign detOn    = enableReg[g];
    assign clsOn    = enableReg[NUM_PORTS+g];
    assign settled  = (cnt == settleCycles);

    always_comb begin
      nxtSt  = curSt;
      cntNxt = '0;
      stb    = '0;
      if ((modeP == MODE_OFF) || hostPwrOff[g]) begin
        nxtSt = ST_IDLE;
      end else if ((modeP == MODE_MANUAL) && (curSt != ST_IDLE) && (curSt != ST_POWER)) begin
        nxtSt = ST_IDLE;
      end else begin
        unique case (curSt)
          ST_IDLE: begin
            if ((modeP == MODE_MANUAL) && hostPwrOn[g]) begin
              nxtSt = ST_POWER;
            end else if (autoLike && detOn) begin
              nxtSt        = ST_DSET1;
              stb.clearRes = 1'b1;
            end
          end
          ST_DSET1, ST_DSET2, ST_CSET: begin
            if (settled) begin
              nxtSt = (curSt == ST_DSET1) ? ST_DREQ1 :
                      (curSt == ST_DSET2) ? ST_DREQ2 : ST_CREQ;
            end else begin
              cntNxt = cnt + 1'b1;
            end
          end
          ST_DREQ1: begin
            if (measValid[g]) begin
              stb.capV1 = 1'b1;
              nxtSt     = ST_DSET2;
            end
          end
          ST_DREQ2: begin
            if (measValid[g]) begin
              stb.capV2 = 1'b1;
              nxtSt     = ST_DEVAL;
            end
          end
          ST_DEVAL: begin
            stb.latchDet = 1'b1;
            if (!sigOk[g]) begin
              nxtSt = ST_IDLE;
            end else if (clsOn) begin
              nxtSt = ST_CSET;
            end else begin
              nxtSt = (modeP == MODE_AUTO) ? ST_POWER : ST_WAITPWR;
            end
          end
          ST_CREQ: begin
            if (measValid[g]) begin
              stb.capClass = 1'b1;
              nxtSt        = ST_CEVAL;
            end
          end
          ST_CEVAL: begin
            nxtSt = (modeP == MODE_AUTO) ? ST_POWER : ST_WAITPWR;
          end
          ST_WAITPWR: begin
            if (hostPwrOn[g]) nxtSt = ST_POWER;
          end
          ST_POWER: begin
            nxtSt = ST_POWER;
          end
          default: nxtSt = ST_IDLE;
        endcase
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        curSt <= ST_IDLE;
        cnt   <= '0;
      end else begin
        curSt <= nxtSt;
        cnt   <= cntNxt;
      end
    end

    assign strobes[g]   = stb;
    assign measReq[g]   = (curSt == ST_DREQ1) || (curSt == ST_DREQ2) || (curSt == ST_CREQ);
    assign measKind[g]  = (curSt == ST_DREQ2) ? KIND_DET2 :
                          (curSt == ST_CREQ)  ? KIND_CLASS : KIND_DET1;
    assign gateOn[g]    = (curSt == ST_POWER);
    assign detectEvt[g] = (curSt == ST_DEVAL);
    assign classEvt[g]  = (curSt == ST_CEVAL);
  end

endmodule

// File: rtl/poeSeqData.sv
module poeSeqData
  import poeSeqPkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int CODE_W    = 10
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  seqStrobe_t [NUM_PORTS-1:0]        strobes,
  input  logic [NUM_PORTS-1:0][CODE_W-1:0]  measCode,
  input  logic [CODE_W-1:0]                 sigMinCode,
  input  logic [CODE_W-1:0]                 sigMaxCode,
  output logic [NUM_PORTS-1:0]              sigOk,
  output logic [NUM_PORTS-1:0][1:0]         detResult,
  output logic [NUM_PORTS-1:0][2:0]         classVal
);

  localparam int DIFF_W = CODE_W + 1;

  for (genvar g = 0; g < NUM_PORTS; g++) begin : gLane
    logic [CODE_W-1:0]        v1Reg, v2Reg;
    logic signed [DIFF_W-1:0] slope;
    logic [1:0]               sigCode;
    logic [1:0]               detReg;
    logic [2:0]               clsReg;

    assign slope = $signed({1'b0, v2Reg}) - $signed({1'b0, v1Reg});

    always_comb begin
      if (slope[DIFF_W-1]) begin
        sigCode = SIG_LOW;
      end else if (slope[CODE_W-1:0] < sigMinCode) begin
        sigCode = SIG_LOW;
      end else if (slope[CODE_W-1:0] > sigMaxCode) begin
        sigCode = SIG_HIGH;
      end else begin
        sigCode = SIG_GOOD;
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        v1Reg  <= '0;
        v2Reg  <= '0;
        detReg <= SIG_NONE;
        clsReg <= '0;
      end else begin
        if (strobes[g].capV1) v1Reg <= measCode[g];
        if (strobes[g].capV2) v2Reg <= measCode[g];
        if (strobes[g].clearRes) begin
          detReg <= SIG_NONE;
          clsReg <= '0;
        end else begin
          if (strobes[g].latchDet) detReg <= sigCode;
          if (strobes[g].capClass) clsReg <= mapClass(measCode[g][2:0]);
        end
      end
    end

    assign sigOk[g]     = (sigCode == SIG_GOOD);
    assign detResult[g] = detReg;
    assign classVal[g]  = clsReg;
  end

endmodule

// File: rtl/poeSequencer.sv
module poeSequencer
  import poeSeqPkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int CODE_W    = 10,
  parameter int CNT_W     = 8
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic [NUM_PORTS-1:0][1:0]         portMode,
  input  logic [2*NUM_PORTS-1:0]            enableReg,
  input  logic [CNT_W-1:0]                  settleCycles,
  input  logic [CODE_W-1:0]                 sigMinCode,
  input  logic [CODE_W-1:0]                 sigMaxCode,
  input  logic [NUM_PORTS-1:0]              hostPwrOn,
  input  logic [NUM_PORTS-1:0]              hostPwrOff,
  input  logic [NUM_PORTS-1:0]              measValid,
  input  logic [NUM_PORTS-1:0][CODE_W-1:0]  measCode,
  output logic [NUM_PORTS-1:0]              measReq,
  output logic [NUM_PORTS-1:0][1:0]         measKind,
  output logic [NUM_PORTS-1:0]              gateOn,
  output logic [NUM_PORTS-1:0][1:0]         detResult,
  output logic [NUM_PORTS-1:0][2:0]         classVal,
  output logic [NUM_PORTS-1:0]              detectEvt,
  output logic [NUM_PORTS-1:0]              classEvt
);

  seqStrobe_t [NUM_PORTS-1:0] strobes;
  logic [NUM_PORTS-1:0]       sigOk;

  poeSeqCtrl #(.NUM_PORTS(NUM_PORTS), .CNT_W(CNT_W)) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .portMode     (portMode),
    .enableReg    (enableReg),
    .settleCycles (settleCycles),
    .hostPwrOn    (hostPwrOn),
    .hostPwrOff   (hostPwrOff),
    .measValid    (measValid),
    .sigOk        (sigOk),
    .strobes      (strobes),
    .measReq      (measReq),
    .measKind     (measKind),
    .gateOn       (gateOn),
    .detectEvt    (detectEvt),
    .classEvt     (classEvt)
  );

  poeSeqData #(.NUM_PORTS(NUM_PORTS), .CODE_W(CODE_W)) u_data (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .measCode   (measCode),
    .sigMinCode (sigMinCode),
    .sigMaxCode (sigMaxCode),
    .sigOk      (sigOk),
    .detResult  (detResult),
    .classVal   (classVal)
  );

endmodule

// File: rtl/poeSeqChecker.sv
module poeSeqChecker
  import poeSeqPkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int CODE_W    = 10
) (
  input logic                              clk,
  input logic                              rstN,
  input logic [NUM_PORTS-1:0][1:0]         portMode,
  input logic [NUM_PORTS-1:0]              hostPwrOff,
  input logic [NUM_PORTS-1:0]              measValid,
  input logic [NUM_PORTS-1:0]              measReq,
  input logic [NUM_PORTS-1:0][1:0]         measKind,
  input logic [NUM_PORTS-1:0]              gateOn,
  input logic [NUM_PORTS-1:0][1:0]         detResult,
  input logic [NUM_PORTS-1:0][2:0]         classVal,
  input logic [NUM_PORTS-1:0]              detectEvt,
  input logic [NUM_PORTS-1:0]              classEvt
);

  for (genvar g = 0; g < NUM_PORTS; g++) begin : gChk
    // R10: off mode or power-off pulse clears the gate on the next cycle
    p_off_gate_r10: assert property (@(posedge clk) disable iff (!rstN)
      ((portMode[g] == MODE_OFF) || hostPwrOff[g]) |=> !gateOn[g]);

    // R4: a pending request holds, unchanged, until its result arrives
    p_req_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
      (measReq[g] && !measValid[g] && portMode[g][1] && !hostPwrOff[g])
        |=> (measReq[g] && $stable(measKind[g])));

    // R6: events, requests and gate drive never overlap on one port
    p_excl_r6: assert property (@(posedge clk) disable iff (!rstN)
      $onehot0({detectEvt[g], classEvt[g], measReq[g], gateOn[g]}));

    // R6: completion events last one cycle
    p_det_pulse_r6: assert property (@(posedge clk) disable iff (!rstN)
      detectEvt[g] |=> !detectEvt[g]);

    // R9: class value never leaves 0..4
    p_class_range_r9: assert property (@(posedge clk) disable iff (!rstN)
      classVal[g] <= CLASS_TOP);

    // R5: a fresh detection starts with cleared results
    p_clear_r5: assert property (@(posedge clk) disable iff (!rstN)
      ($rose(measReq[g]) && (measKind[g] == KIND_DET1))
        |-> ((detResult[g] == SIG_NONE) && (classVal[g] == 3'd0)));
  end

endmodule

bind poeSequencer poeSeqChecker #(.NUM_PORTS(NUM_PORTS), .CODE_W(CODE_W)) u_checker (
  .clk        (clk),
  .rstN       (rstN),
  .portMode   (portMode),
  .hostPwrOff (hostPwrOff),
  .measValid  (measValid),
  .measReq    (measReq),
  .measKind   (measKind),
  .gateOn     (gateOn),
  .detResult  (detResult),
  .classVal   (classVal),
  .detectEvt  (detectEvt),
  .classEvt   (classEvt)
);

// File: tb/test_poeSequencer.sv
module test_poeSequencer;

  localparam int N      = 4;
  localparam int CODE_W = 10;
  localparam int CNT_W  = 8;
  localparam int LIMIT  = 20000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #5 clk = ~clk;

  logic [N-1:0][1:0]        portMode;
  logic [2*N-1:0]           enableReg;
  logic [CNT_W-1:0]         settleCycles;
  logic [CODE_W-1:0]        sigMinCode, sigMaxCode;
  logic [N-1:0]             hostPwrOn, hostPwrOff, measValid;
  logic [N-1:0][CODE_W-1:0] measCode;
  logic [N-1:0]             measReq, gateOn, detectEvt, classEvt;
  logic [N-1:0][1:0]        measKind, detResult;
  logic [N-1:0][2:0]        classVal;

  poeSequencer #(.NUM_PORTS(N), .CODE_W(CODE_W), .CNT_W(CNT_W)) i_poeSequencer (
    .clk(clk), .rstN(rstN), .portMode(portMode), .enableReg(enableReg),
    .settleCycles(settleCycles), .sigMinCode(sigMinCode), .sigMaxCode(sigMaxCode),
    .hostPwrOn(hostPwrOn), .hostPwrOff(hostPwrOff), .measValid(measValid),
    .measCode(measCode), .measReq(measReq), .measKind(measKind), .gateOn(gateOn),
    .detResult(detResult), .classVal(classVal), .detectEvt(detectEvt), .classEvt(classEvt)
  );

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  // reference model: phase 0 idle, 1/3/6 settling, 2/4/7 requesting,
  // 5 detect done, 8 class done, 9 waiting for host, 10 powered
  int mPh[N], mCnt[N], mV1[N], mV2[N], mRes[N], mCls[N];
  int lat[N], rCnt[N], codeA[N], codeB[N], codeC[N];

  task automatic modelStep(input int p);
    int md, d, raw;
    md = int'(portMode[p]);
    if (md == 0 || hostPwrOff[p] || (md == 1 && mPh[p] != 0 && mPh[p] != 10)) begin
      mPh[p] = 0; mCnt[p] = 0;
      return;
    end
    case (mPh[p])
      0: if (md == 1 && hostPwrOn[p]) mPh[p] = 10;
         else if (md >= 2 && enableReg[p]) begin
           mPh[p] = 1; mCnt[p] = 0; mRes[p] = 0; mCls[p] = 0;
         end
      1, 3, 6: if (mCnt[p] == int'(settleCycles)) begin mPh[p] = mPh[p] + 1; mCnt[p] = 0; end
               else mCnt[p] = mCnt[p] + 1;
      2: if (measValid[p]) begin mV1[p] = int'(measCode[p]); mPh[p] = 3; end
      4: if (measValid[p]) begin mV2[p] = int'(measCode[p]); mPh[p] = 5; end
      7: if (measValid[p]) begin
           raw = int'(measCode[p]) % 8;
           mCls[p] = (raw > 4) ? 0 : raw;
           mPh[p] = 8;
         end
      5: begin
           d = mV2[p] - mV1[p];
           if (d < int'(sigMinCode)) mRes[p] = 2;
           else if (d > int'(sigMaxCode)) mRes[p] = 3;
           else mRes[p] = 1;
           if (mRes[p] != 1) mPh[p] = 0;
           else if (enableReg[N+p]) begin mPh[p] = 6; mCnt[p] = 0; end
           else mPh[p] = (md == 3) ? 10 : 9;
         end
      8: mPh[p] = (md == 3) ? 10 : 9;
      9: if (hostPwrOn[p]) mPh[p] = 10;
      default: ;
    endcase
  endtask

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int p = 0; p < N; p++) begin
        mPh[p] = 0; mCnt[p] = 0; mV1[p] = 0; mV2[p] = 0; mRes[p] = 0; mCls[p] = 0;
      end
    end else begin
      for (int p = 0; p < N; p++) modelStep(p);
    end
  end

  task automatic chk(input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", what, act, exp, cycles);
    end
  endtask

  function automatic bit isReq(input int ph);
    return ph == 2 || ph == 4 || ph == 7;
  endfunction

  task automatic compareAll();
    for (int p = 0; p < N; p++) begin
      chk(int'(gateOn[p]), int'(mPh[p] == 10), $sformatf("R7 R8 R10 R11 gateOn port%0d", p));
      chk(int'(measReq[p]), int'(isReq(mPh[p])), $sformatf("R3 R4 measReq port%0d", p));
      chk(int'(measKind[p]), (mPh[p] == 4) ? 1 : (mPh[p] == 7) ? 2 : 0,
          $sformatf("R3 measKind port%0d", p));
      chk(int'(detResult[p]), mRes[p], $sformatf("R5 detResult port%0d", p));
      chk(int'(classVal[p]), mCls[p], $sformatf("R9 classVal port%0d", p));
      chk(int'(detectEvt[p]), int'(mPh[p] == 5), $sformatf("R6 detectEvt port%0d", p));
      chk(int'(classEvt[p]), int'(mPh[p] == 8), $sformatf("R6 classEvt port%0d", p));
    end
  endtask

  task automatic respond();
    for (int p = 0; p < N; p++) begin
      measValid[p] = 1'b0;
      if (isReq(mPh[p])) begin
        if (rCnt[p] >= lat[p]) begin
          measValid[p] = 1'b1;
          measCode[p]  = CODE_W'((mPh[p] == 2) ? codeA[p] : (mPh[p] == 4) ? codeB[p] : codeC[p]);
          rCnt[p] = 0;
        end else rCnt[p] = rCnt[p] + 1;
      end else rCnt[p] = 0;
    end
  endtask

  task automatic step();
    @(negedge clk);
    cycles++;
    if (cycles > LIMIT) begin
      errors++;
      $display("FAIL watchdog expired after %0d cycles", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
    compareAll();
    respond();
  endtask

  task automatic steps(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  // which: 0 detectEvt, 1 classEvt, 2 gateOn, 3 phase-2 result being returned
  task automatic waitFor(input int p, input int which, input string what);
    bit hit = 0;
    for (int i = 0; i < 600 && !hit; i++) begin
      step();
      case (which)
        0: hit = detectEvt[p];
        1: hit = classEvt[p];
        2: hit = gateOn[p];
        default: hit = (mPh[p] == 4) && measValid[p];
      endcase
    end
    chk(int'(hit), 1, what);
  endtask

  task automatic pulseOn(input int p);
    hostPwrOn[p] = 1'b1; step(); hostPwrOn[p] = 1'b0;
  endtask

  task automatic pulseOff(input int p);
    hostPwrOff[p] = 1'b1; step(); hostPwrOff[p] = 1'b0;
  endtask

  initial begin
    portMode = '0; enableReg = '0; settleCycles = 8'd3;
    sigMinCode = 10'd190; sigMaxCode = 10'd265;
    hostPwrOn = '0; hostPwrOff = '0; measValid = '0; measCode = '0;
    for (int p = 0; p < N; p++) begin
      lat[p] = p + 1; rCnt[p] = 0; codeA[p] = 0; codeB[p] = 0; codeC[p] = 0;
    end
    steps(2);
    rstN = 1'b1;
    step();
    // R1: reset state
    chk(int'(gateOn), 0, "R1 gateOn after reset");
    chk(int'(measReq), 0, "R1 measReq after reset");
    chk(int'(detResult), 0, "R1 detResult after reset");
    chk(int'(classVal), 0, "R1 classVal after reset");
    chk(int'(detectEvt | classEvt), 0, "R1 events after reset");

    // R2: automatic modes but no enable bits, nothing starts
    portMode = {2'd1, 2'd3, 2'd2, 2'd3};
    steps(12);
    chk(int'(measReq), 0, "R2 no request without enable bits");

    codeA[0] = 120; codeB[0] = 370; codeC[0] = 4;   // slope 250, class 4
    codeA[1] = 50;  codeB[1] = 240; codeC[1] = 6;   // slope 190 = min, class 6 -> 0
    codeA[2] = 300; codeB[2] = 350;                 // slope 50, low
    enableReg = 8'b0011_0111;

    waitFor(0, 2, "R7 port0 auto reaches gate on");
    chk(int'(detResult[0]), 1, "R5 port0 valid signature");
    chk(int'(classVal[0]), 4, "R9 port0 reserved class 4 kept");

    waitFor(1, 1, "R6 port1 class event");
    steps(6);
    chk(int'(gateOn[1]), 0, "R8 port1 semi holds gate off");
    chk(int'(classVal[1]), 0, "R9 port1 class 6 reported as 0");
    chk(int'(detResult[1]), 1, "R5 port1 slope at lower bound valid");
    pulseOn(1);
    step();
    chk(int'(gateOn[1]), 1, "R8 port1 gate after host pulse");

    waitFor(2, 0, "R6 port2 detect event");
    step();
    chk(int'(detResult[2]), 2, "R5 port2 short slope");
    codeB[2] = 300 + 266;
    waitFor(2, 0, "R6 port2 second detect");
    step();
    chk(int'(detResult[2]), 3, "R5 port2 open slope above max");
    codeB[2] = 290;
    waitFor(2, 0, "R6 port2 third detect");
    step();
    chk(int'(detResult[2]), 2, "R5 port2 negative slope low");
    codeB[2] = 300 + 265;
    waitFor(2, 2, "R7 port2 powers with class disabled");
    chk(int'(detResult[2]), 1, "R5 port2 slope at upper bound valid");

    // R10 manual: no requests, host controls gate
    chk(int'(measReq[3]), 0, "R10 manual port3 never requests");
    pulseOn(3);
    step();
    chk(int'(gateOn[3]), 1, "R10 manual port3 gate on");
    chk(int'(gateOn[0]), 1, "R11 port0 unaffected by port3");
    pulseOff(3);
    step();
    chk(int'(gateOn[3]), 0, "R10 port3 off after host pulse");

    // R10 abort wins over a result arriving in the same cycle
    pulseOff(1);
    waitFor(1, 3, "R10 port1 phase-2 result returning");
    portMode[1] = 2'd0;
    steps(10);
    chk(int'(detResult[1]), 0, "R10 aborted port1 result not latched");
    chk(int'(measReq[1]), 0, "R10 aborted port1 idle");

    // R10 off mode drops a powered port
    portMode[0] = 2'd0;
    steps(2);
    chk(int'(gateOn[0]), 0, "R10 port0 gate off in off mode");

    // R3 with zero settle, port0 auto again
    settleCycles = 8'd0;
    portMode[0] = 2'd3;
    waitFor(0, 2, "R3 port0 sequence with zero settle");
    steps(5);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule